// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous memory array uses on each clock cycle. When a new access is accepted, it captures a base address. On each following continue cycle it moves through a four-beat burst by changing only the two lowest address bits. A static order input selects the beat order. The order is either a wrapping linear count or an interleaved order, in which the starting low bits are XORed with a beat counter. The upper address bits keep the loaded value for the whole burst.

The control inputs are plain and level-sampled on the rising clock edge. There are no data streams, so the block has no valid/ready handshake. The inputs work as follows:

- `advance` low with the device selected loads a new burst.
- `advance` low while deselected ends any burst in progress.
- `advance` high steps an active burst and ignores the base address.
- `stall` high freezes every register, as if the clock edge had not occurred.

The current address and a burst-active flag are registered outputs. Each one changes in the cycle after the edge that sampled the command.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `addr` is 0 and `burst_active` is 0.
- R2: A load happens on an edge that samples `stall`=0, `advance`=0 and `sel`=1. After that edge, `addr` equals `base_addr` and `burst_active` is 1. A load also restarts a burst that is already in progress.
- R3: With `interleave`=0, each advance of an active burst sets the low two bits of `addr` to the previous low bits plus 1, modulo 4.
- R4: With `interleave`=1, the k-th advance after a load (k = 1, 2, 3) sets the low two bits to the loaded low bits XOR k.
- R5: In both orders, the fourth advance after a load returns `addr` to the loaded address. Further advances repeat the same four-beat cycle.
- R6: On an advance edge (`advance`=1), `base_addr` has no effect on `addr`.
- R7: An edge with `stall`=0, `advance`=0 and `sel`=0 clears `burst_active` and leaves `addr` unchanged.
- R8: An edge with `stall`=1 leaves `addr` and `burst_active` unchanged, whatever the other inputs are. This holds even when the edge would otherwise load or terminate.
- R9: An advance edge while `burst_active` is 0 leaves `addr` unchanged and `burst_active` at 0.
- R10: `addr` bits above bit 1 change only on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | High freezes all state for this edge |
| advance | input | 1 | High steps the burst; low loads a new burst or terminates the current one |
| sel | input | 1 | Device-selected status, sampled when `advance` is low |
| interleave | input | 1 | Static order select: 1 interleaved, 0 linear |
| base_addr | input | ADDR_W (17) | Start address captured on a load |
| addr | output | ADDR_W (17) | Current array address |
| burst_active | output | 1 | A burst is in progress |

## Verification
The sharpest overlap is a freeze that falls on a cycle that also asks for a load or a terminate. The bench forces `stall` high together with `advance` low, in both the selected and the deselected case, in the middle of a burst. It then checks that neither the new base address nor the cleared flag appears, and that the burst resumes its next beat once the freeze lifts. Random stimulus also places loads directly on top of a running burst and on the wrap beat. A bench model built from the requirements judges every cycle for both orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    CMD_HOLD,
    CMD_LOAD,
    CMD_STOP,
    CMD_STEP,
    CMD_NOP
  } seq_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_seq_pkg::*;
(
  input  logic     stall,
  input  logic     advance,
  input  logic     sel,
  input  logic     active,
  output seq_cmd_e cmd
);
  // Freeze has top priority; then load/terminate; then stepping.
  always_comb begin
    if (stall)         cmd = CMD_HOLD;
    else if (!advance) cmd = sel ? CMD_LOAD : CMD_STOP;
    else if (active)   cmd = CMD_STEP;
    else               cmd = CMD_NOP;
  end
endmodule

// File: rtl/burst_order_step.sv
module burst_order_step #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_low,
  input  logic [CNT_W-1:0] beat_cnt,
  input  logic             interleave,
  output logic [CNT_W-1:0] next_cnt,
  output logic [CNT_W-1:0] next_low
);
  logic [CNT_W-1:0] lin_low;
  logic [CNT_W-1:0] ilv_low;

  assign next_cnt = beat_cnt + 1'b1;
  assign lin_low  = start_low + next_cnt;

  // Interleaved order: each low bit flips independently by the beat count.
  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv_low[b] = start_low[b] ^ next_cnt[b];
  end

  assign next_low = interleave ? ilv_low : lin_low;
endmodule

// File: rtl/burst_addr_state.sv
module burst_addr_state
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_cmd_e          cmd,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  next_low,
  input  logic [CNT_W-1:0]  next_cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic [CNT_W-1:0]  start_low,
  output logic [CNT_W-1:0]  beat_cnt
);
  localparam logic [CNT_W-1:0] LAST_BEAT = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr      <= '0;
      active    <= 1'b0;
      start_low <= '0;
      beat_cnt  <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          addr      <= base_addr;
          active    <= 1'b1;
          start_low <= base_addr[CNT_W-1:0];
          beat_cnt  <= '0;
        end
        CMD_STOP: active <= 1'b0;
        CMD_STEP: begin
          addr[CNT_W-1:0] <= next_low;
          beat_cnt        <= next_cnt;
        end
        default: ;
      endcase
    end
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (addr == $past(base_addr)) && active);

  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP) |=> !active && $stable(addr));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=> $stable(addr) && $stable(active));

  p_idle_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) |=> $stable(addr) && !active);

  p_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_LOAD) |=> $stable(addr[ADDR_W-1:CNT_W]));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STEP && beat_cnt == LAST_BEAT) |=> (addr[CNT_W-1:0] == start_low));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              advance,
  input  logic              sel,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              burst_active
);
  localparam int CNT_W = $clog2(BURST_LEN);

  seq_cmd_e         cmd;
  logic [CNT_W-1:0] start_low;
  logic [CNT_W-1:0] beat_cnt;
  logic [CNT_W-1:0] next_low;
  logic [CNT_W-1:0] next_cnt;

  burst_cmd_decode u_decode (
    .stall   (stall),
    .advance (advance),
    .sel     (sel),
    .active  (burst_active),
    .cmd     (cmd)
  );

  burst_order_step #(.CNT_W(CNT_W)) u_order (
    .start_low  (start_low),
    .beat_cnt   (beat_cnt),
    .interleave (interleave),
    .next_cnt   (next_cnt),
    .next_low   (next_low)
  );

  burst_addr_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .base_addr (base_addr),
    .next_low  (next_low),
    .next_cnt  (next_cnt),
    .addr      (addr),
    .active    (burst_active),
    .start_low (start_low),
    .beat_cnt  (beat_cnt)
  );

  p_step_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && advance) |=> (addr[ADDR_W-1:CNT_W] == $past(addr[ADDR_W-1:CNT_W])));
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n, stall, advance, sel, interleave;
  logic [AW-1:0] base_addr, addr;
  logic          burst_active;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] m_addr;
  logic          m_act;
  logic [1:0]    m_start, m_cnt;

  always #5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .stall(stall), .advance(advance), .sel(sel),
    .interleave(interleave), .base_addr(base_addr), .addr(addr),
    .burst_active(burst_active)
  );

  function automatic logic [1:0] beat_low(logic [1:0] st, logic [1:0] k, logic il);
    return il ? (st ^ k) : (st + k);
  endfunction

  task automatic check(string req, logic [AW-1:0] ea, logic ev);
    checks++;
    if (addr !== ea || burst_active !== ev) begin
      errors++;
      $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
               req, addr, burst_active, ea, ev);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_addr = '0; m_act = 0; m_start = 0; m_cnt = 0;
    end else if (!stall) begin
      if (!advance) begin
        if (sel) begin
          m_addr = base_addr; m_start = base_addr[1:0]; m_cnt = 0; m_act = 1;
        end else m_act = 0;
      end else if (m_act) begin
        m_cnt = m_cnt + 1;
        m_addr[1:0] = beat_low(m_start, m_cnt, interleave);
      end
    end
  endtask

  // Drive at negedge, let one edge pass, check at the next negedge.
  task automatic cyc(logic s, logic a, logic se, logic [AW-1:0] b, string req);
    stall = s; advance = a; sel = se; base_addr = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, m_addr, m_act);
  endtask

  task automatic expect_lit(string req, logic [AW-1:0] ea, logic ev);
    check(req, ea, ev);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hB0057));
    rst_n = 0; stall = 0; advance = 0; sel = 1; interleave = 0; base_addr = 17'h1FFFF;
    m_addr = '0; m_act = 0; m_start = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", '0, 0);
    rst_n = 1; advance = 1; sel = 0;
    @(negedge clk);
    check("R1 after release", '0, 0);

    // R9: advance with nothing active
    cyc(0, 1, 1, 17'h00F0F, "R9 idle advance");
    expect_lit("R9", '0, 0);

    // Linear burst from low bits 01
    interleave = 0;
    cyc(0, 0, 1, 17'h0A5A5, "R2 load");
    expect_lit("R2", 17'h0A5A5, 1);
    cyc(0, 1, 1, 17'h1FFFF, "R3 linear beat1 R6");
    expect_lit("R3", 17'h0A5A6, 1);
    cyc(0, 1, 0, 17'h00000, "R3 linear beat2 R6");
    expect_lit("R3", 17'h0A5A7, 1);
    cyc(0, 1, 1, 17'h12345, "R3 linear beat3");
    expect_lit("R3", 17'h0A5A4, 1);
    cyc(0, 1, 1, 17'h12345, "R5 linear wrap");
    expect_lit("R5", 17'h0A5A5, 1);

    // Interleaved burst from low bits 01 -> 0,3,2,1
    interleave = 1;
    cyc(0, 0, 1, 17'h05555, "R2 reload");
    cyc(0, 1, 1, 17'h0, "R4 ilv beat1");
    expect_lit("R4", 17'h05554, 1);
    // R8: stall on top of a load and on top of a terminate
    cyc(1, 0, 1, 17'h1ABCD, "R8 stall over load");
    expect_lit("R8", 17'h05554, 1);
    cyc(1, 0, 0, 17'h1ABCD, "R8 stall over terminate");
    expect_lit("R8", 17'h05554, 1);
    cyc(0, 1, 1, 17'h0, "R4 ilv beat2");
    expect_lit("R4", 17'h05557, 1);
    cyc(0, 1, 1, 17'h0, "R4 ilv beat3");
    expect_lit("R4", 17'h05556, 1);
    cyc(0, 1, 1, 17'h0, "R5 ilv wrap");
    expect_lit("R5", 17'h05555, 1);

    // R7 terminate, then advance does nothing
    cyc(0, 0, 0, 17'h1FFFF, "R7 terminate");
    expect_lit("R7", 17'h05555, 0);
    cyc(0, 1, 1, 17'h1FFFF, "R9 advance after terminate");
    expect_lit("R9", 17'h05555, 0);

    // Random mix, both orders
    for (int i = 0; i < 3000; i++) begin
      logic s, a, se;
      logic [AW-1:0] b;
      string req;
      if (i % 300 == 0) interleave = $urandom_range(0, 1);
      s  = ($urandom_range(0, 99) < 15);
      a  = ($urandom_range(0, 99) < 70);
      se = ($urandom_range(0, 99) < 80);
      b  = AW'($urandom);
      if (s) req = "R8 random stall";
      else if (!a && se) req = "R2 random load";
      else if (!a) req = "R7 random terminate";
      else if (!m_act) req = "R9 random idle advance";
      else if (interleave) req = "R4 R6 R10 random beat";
      else req = "R3 R6 R10 random beat";
      cyc(s, a, se, b, req);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule